// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Five Decade Counter

This block is a four-bit counter made of two sections. A one-bit divide-by-two section drives `qa`. A three-bit divide-by-five section drives `qd qc qb`, with `qd` as its most significant bit. Each section has its own count-strobe input. A section advances only when its strobe goes from high to low. Everything runs on one system clock. Strobes are detected as falling edges after a two-flop synchronizer, and the sections are never clocked directly.

A two-bit link-mode input selects how the two sections are wired:

- **Separate:** each section counts its own strobe.
- **Decade (BCD):** the falling edge of `qa` advances the divide-by-five section.
- **Bi-quinary:** the divide-by-five section counts the external strobe, and the falling edge of `qd` advances the divide-by-two section. This gives `qa` as a square wave at one tenth of the strobe rate.

A terminal-count flag marks the last state of each chained sequence. Two instances can be cascaded to divide by one hundred. Reset clears both sections together. It is applied at once and released on the clock.

Top module: `split_decade_counter`

## Requirements
- R1: While `rst` is high, `qa`, `qb`, `qc`, `qd` and `tc` are 0, even between clock edges, and no strobe advances either section.
- R2: In separate mode (`link_mode` 00 or 11), each falling edge on `strobe_a` toggles `qa`. A rising edge on `strobe_a` leaves all outputs unchanged.
- R3: Each count event of the divide-by-five section steps {qd,qc,qb} through 000, 001, 010, 011, 100 and then back to 000.
- R4: In separate mode, strobing one section leaves the other section's outputs unchanged.
- R5: In decade mode (`link_mode` 01), falling edges on `strobe_a` make {qd,qc,qb,qa} count 0 through 9 and wrap to 0. `strobe_b` has no effect in this mode.
- R6: In bi-quinary mode (`link_mode` 10), falling edges on `strobe_b` make {qa,qd,qc,qb} run 0, 1, 2, 3, 4, 8, 9, 10, 11, 12 and then 0. `strobe_a` has no effect in this mode.
- R7: In bi-quinary mode, `qa` is high for exactly five of every ten strobes.
- R8: `tc` is high while the decade value is 9 in mode 01, and while the bi-quinary value is 12 in mode 10. It stays low in separate mode.
- R9: An output changes on the third rising clock edge after its external strobe falls: two synchronizer flops plus one compare register.
- R10: After reset is released, the first falling edge of a strobe counts exactly once, even if that strobe was held high across the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, asserted asynchronously and released synchronously |
| link_mode | input | 2 | 00/11 separate, 01 decade, 10 bi-quinary |
| strobe_a | input | 1 | Count strobe of the divide-by-two section |
| strobe_b | input | 1 | Count strobe of the divide-by-five section |
| qa | output | 1 | Divide-by-two output |
| qb | output | 1 | Divide-by-five bit 0 |
| qc | output | 1 | Divide-by-five bit 1 |
| qd | output | 1 | Divide-by-five bit 2 (MSB) |
| tc | output | 1 | Terminal-count flag |

## Verification
In the chained modes, the upstream bit's falling edge and a count event on the downstream section happen in consecutive cycles. At a wrap, one strobe therefore moves both sections. The bench provokes this at the decade 9-to-0 step and at the bi-quinary 4-to-8 and 12-to-0 steps, and judges the settled word after both sections have moved. Assertions confirm that the downstream section really moves in the cycle after each link edge. The bench also drives a strobe that is already high while reset is released. It then checks that the first fall counts once, with neither a phantom nor a lost count.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    LINK_SEPARATE  = 2'b00,
    LINK_DECADE    = 2'b01,
    LINK_BIQUINARY = 2'b10,
    LINK_SEPARATE2 = 2'b11
  } link_mode_e;

  localparam int QUINT_W = 3;
  localparam logic [QUINT_W-1:0] QUINT_LAST = 3'd4;

  // next state of the five-state section; any code above the last state folds to zero
  function automatic logic [QUINT_W-1:0] quint_next(input logic [QUINT_W-1:0] v);
    return (v >= QUINT_LAST) ? '0 : v + 1'b1;
  endfunction

  // decade terminal: value nine
  function automatic logic is_decade_end(input logic a, input logic [QUINT_W-1:0] v);
    return a && (v == QUINT_LAST);
  endfunction

  // bi-quinary terminal: value twelve
  function automatic logic is_biq_end(input logic a, input logic [QUINT_W-1:0] v);
    return a && (v == QUINT_LAST);
  endfunction
endpackage

// File: rtl/sdc_strobe_edge.sv
module sdc_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_q,
  input  logic din,
  output logic fall
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_sh;
  logic         last_lvl;

  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) begin
      sync_sh  <= '0;
      last_lvl <= 1'b0;
    end else begin
      sync_sh  <= {sync_sh[MSB-1:0], din};
      last_lvl <= sync_sh[MSB];
    end
  end

  assign fall = last_lvl & ~sync_sh[MSB];
endmodule

// File: rtl/sdc_div2.sv
module sdc_div2 (
  input  logic clk,
  input  logic rst_q,
  input  logic en,
  output logic q
);
  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) q <= 1'b0;
    else if (en) q <= ~q;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst_q) !en |=> $stable(q))
    else $error("divide-by-two moved without a count event");
endmodule

// File: rtl/sdc_div5.sv
module sdc_div5
  import sdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_q,
  input  logic               en,
  output logic [QUINT_W-1:0] value
);
  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) value <= '0;
    else if (en) value <= quint_next(value);
  end

  a_r3_legal: assert property (@(posedge clk) disable iff (rst_q) value <= QUINT_LAST)
    else $error("divide-by-five holds an unused code");
  a_r3_hold: assert property (@(posedge clk) disable iff (rst_q) !en |=> $stable(value))
    else $error("divide-by-five moved without a count event");
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst_q)
                              (en && value == QUINT_LAST) |=> value == '0)
    else $error("divide-by-five failed to wrap");
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] link_mode,
  input  logic       strobe_a,
  input  logic       strobe_b,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd,
  output logic       tc
);
  logic [RST_STAGES-1:0] rst_sh;
  logic                  rst_q;

  // applied at once, released on the clock
  always_ff @(posedge clk or posedge rst) begin
    if (rst) rst_sh <= '1;
    else     rst_sh <= {rst_sh[RST_STAGES-2:0], 1'b0};
  end
  assign rst_q = rst_sh[RST_STAGES-1];

  logic ext_fall_a, ext_fall_b;

  sdc_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .rst_q(rst_q), .din(strobe_a), .fall(ext_fall_a));
  sdc_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .rst_q(rst_q), .din(strobe_b), .fall(ext_fall_b));

  logic               two_q;
  logic [QUINT_W-1:0] five_v;
  logic               two_last, msb_last;
  logic               link_fall_a, link_fall_d;
  logic               two_en, five_en;
  link_mode_e         mode;

  assign mode = link_mode_e'(link_mode);

  always_ff @(posedge clk or posedge rst_q) begin
    if (rst_q) begin
      two_last <= 1'b0;
      msb_last <= 1'b0;
    end else begin
      two_last <= two_q;
      msb_last <= five_v[QUINT_W-1];
    end
  end
  assign link_fall_a = two_last & ~two_q;
  assign link_fall_d = msb_last & ~five_v[QUINT_W-1];

  always_comb begin
    case (mode)
      LINK_DECADE: begin
        two_en  = ext_fall_a;
        five_en = link_fall_a;
      end
      LINK_BIQUINARY: begin
        two_en  = link_fall_d;
        five_en = ext_fall_b;
      end
      default: begin
        two_en  = ext_fall_a;
        five_en = ext_fall_b;
      end
    endcase
  end

  sdc_div2 u_two (.clk(clk), .rst_q(rst_q), .en(two_en), .q(two_q));
  sdc_div5 u_five (.clk(clk), .rst_q(rst_q), .en(five_en), .value(five_v));

  assign qa = two_q;
  assign qb = five_v[0];
  assign qc = five_v[1];
  assign qd = five_v[2];

  always_comb begin
    case (mode)
      LINK_DECADE:    tc = is_decade_end(two_q, five_v);
      LINK_BIQUINARY: tc = is_biq_end(two_q, five_v);
      default:        tc = 1'b0;
    endcase
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |-> !(qa || qb || qc || qd || tc))
    else $error("outputs not clear under reset");
  a_r5_decade_link: assert property (@(posedge clk) disable iff (rst_q)
                                     (mode == LINK_DECADE && $fell(qa)) |=> !$stable({qd, qc, qb}))
    else $error("decade link did not advance the five-state section");
  a_r6_biq_link: assert property (@(posedge clk) disable iff (rst_q)
                                  (mode == LINK_BIQUINARY && $fell(qd)) |=> !$stable(qa))
    else $error("bi-quinary link did not toggle the two-state section");
  a_r8_tc_low_separate: assert property (@(posedge clk) disable iff (rst_q)
                                         (link_mode == 2'b00 || link_mode == 2'b11) |-> !tc)
    else $error("terminal flag raised in separate mode");
endmodule

// File: tb/split_decade_counter_bench.sv
module split_decade_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] link_mode = 2'b00;
  logic       strobe_a = 1'b0, strobe_b = 1'b0;
  logic       qa, qb, qc, qd, tc;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  split_decade_counter u_split_decade_counter (
    .clk(clk), .rst(rst), .link_mode(link_mode), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .tc(tc));

  // entry: {mode[1:0], on_b, expected word[3:0], expected tc}
  localparam int NV = 29;
  localparam logic [7:0] VECS [0:NV-1] = '{
    {2'b01,1'b0,4'd1,1'b0},  {2'b01,1'b0,4'd2,1'b0},  {2'b01,1'b0,4'd3,1'b0},
    {2'b01,1'b0,4'd4,1'b0},  {2'b01,1'b0,4'd5,1'b0},  {2'b01,1'b0,4'd6,1'b0},
    {2'b01,1'b0,4'd7,1'b0},  {2'b01,1'b0,4'd8,1'b0},  {2'b01,1'b0,4'd9,1'b1},
    {2'b01,1'b0,4'd0,1'b0},
    {2'b10,1'b1,4'd1,1'b0},  {2'b10,1'b1,4'd2,1'b0},  {2'b10,1'b1,4'd3,1'b0},
    {2'b10,1'b1,4'd4,1'b0},  {2'b10,1'b1,4'd8,1'b0},  {2'b10,1'b1,4'd9,1'b0},
    {2'b10,1'b1,4'd10,1'b0}, {2'b10,1'b1,4'd11,1'b0}, {2'b10,1'b1,4'd12,1'b1},
    {2'b10,1'b1,4'd0,1'b0},
    {2'b00,1'b0,4'd1,1'b0},  {2'b00,1'b1,4'd3,1'b0},  {2'b00,1'b1,4'd5,1'b0},
    {2'b00,1'b1,4'd7,1'b0},  {2'b00,1'b1,4'd9,1'b0},  {2'b00,1'b1,4'd1,1'b0},
    {2'b00,1'b0,4'd0,1'b0},
    {2'b11,1'b0,4'd1,1'b0},  {2'b11,1'b1,4'd3,1'b0}
  };

  function automatic logic [3:0] word_of(input logic [1:0] m);
    return (m == 2'b10) ? {qa, qd, qc, qb} : {qd, qc, qb, qa};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_reset(input logic [1:0] m);
    rst = 1'b1;
    link_mode = m;
    strobe_a = 1'b0;
    strobe_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input logic on_b);
    if (on_b) strobe_b = 1'b1; else strobe_a = 1'b1;
    repeat (4) @(negedge clk);
    if (on_b) strobe_b = 1'b0; else strobe_a = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur_mode;
    int highs;

    // R1 reset state
    go_reset(2'b01);
    check("R1 reset word", {qd, qc, qb, qa}, 4'd0);
    check("R1 reset tc", {3'b0, tc}, 4'd0);

    // vector walk: R2 R3 R4 R5 R6 R8
    cur_mode = 2'bxx;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][7:6] !== cur_mode) begin
        cur_mode = VECS[i][7:6];
        go_reset(cur_mode);
      end
      pulse(VECS[i][5]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), word_of(cur_mode), VECS[i][4:1]);
      check($sformatf("R8 tc vector %0d", i), {3'b0, tc}, {3'b0, VECS[i][0]});
    end

    // R2: a rising edge alone does nothing
    go_reset(2'b00);
    strobe_a = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 rising edge ignored", {qd, qc, qb, qa}, 4'd0);

    // R9: output moves on the third edge after the fall
    @(negedge clk);
    strobe_a = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 unchanged after two edges", {3'b0, qa}, 4'd0);
    @(negedge clk);
    check("R9 changed on third edge", {3'b0, qa}, 4'd1);

    // R5: strobe_b ignored in decade mode
    go_reset(2'b01);
    pulse(1'b0);
    pulse(1'b1);
    check("R5 strobe_b ignored", {qd, qc, qb, qa}, 4'd1);

    // R6 and R7: strobe_a ignored, qa high for five of ten
    go_reset(2'b10);
    pulse(1'b1);
    pulse(1'b0);
    check("R6 strobe_a ignored", {qa, qd, qc, qb}, 4'd1);
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      pulse(1'b1);
      if (qa) highs++;
    end
    check("R7 qa duty", 4'(highs), 4'd5);

    // R1: asynchronous clear mid-count, no counting under reset
    go_reset(2'b01);
    pulse(1'b0);
    pulse(1'b0);
    pulse(1'b0);
    @(negedge clk);
    #3 rst = 1'b1;
    #2 check("R1 async clear", {qd, qc, qb, qa}, 4'd0);
    pulse(1'b0);
    check("R1 no count under reset", {qd, qc, qb, qa}, 4'd0);

    // R10: strobe high across release, first fall counts once
    strobe_a = 1'b1;
    link_mode = 2'b01;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    strobe_a = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 first fall counts once", {qd, qc, qb, qa}, 4'd1);
    repeat (10) @(negedge clk);
    check("R10 no extra count", {qd, qc, qb, qa}, 4'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule